// File: doc/BRIEF.md
# Interrupt acceptance and priority arbiter

This block is the accept-and-dispatch core of a per-core interrupt controller. Incoming interrupt messages arrive as a vector, a delivery mode and a trigger flag. Ordinary requests (fixed and lowest-priority modes) go into a request array with one bit per vector, with a matching trigger-mode array beside it. Four special classes each have their own pending latch and stored vector: system-management, non-maskable, init and external. A third array, the in-service array, records fixed interrupts that the core has accepted and not yet retired.

From this state and the core's interrupt-enable input, the block decides whether to present an interrupt to the core. When the core acknowledges, the block reports the vector, its class and its trigger mode in the same cycle, then updates its state at the clock edge. An end-of-interrupt pulse retires the highest in-service vector. Decoding the register bus and routing messages happen outside this block.

Top module: `irq_accept_arb`

## Requirements
- R1: After reset, all three arrays are empty and no latch is pending. `intr_pending` is 0, and an acknowledge is not honoured (`ack_valid` 0).
- R2: The delivery-mode encoding is 0 fixed, 1 lowest-priority, 2 system-management, 4 non-maskable, 5 init and 7 external. A fixed or lowest-priority request sets the request bit of its vector, and both modes behave identically from then on.
- R3: Each special class (modes 2, 4, 5, 7) latches its vector. A request of a class whose latch is still pending is dropped, and the stored vector stays unchanged.
- R4: A pending system-management, non-maskable or init interrupt is presented whatever `int_enable` is. A pending external interrupt, or a fixed one, is presented only while `int_enable` is 1.
- R5: A fixed request qualifies only when the highest request vector is numerically above the highest in-service vector (0 when that array is empty). Its upper PRIO_W bits must also exceed the same bits of `task_prio`. An empty request array reports vector 0, which therefore never qualifies.
- R6: On acknowledge, delivery order is system-management, non-maskable, init, external, then the highest fixed request. `ack_class` reads 1, 2, 3, 4 and 5 for these respectively, and 0 when nothing is delivered. Only the latch that was delivered is cleared.
- R7: Delivering a fixed interrupt clears its request bit and sets its in-service bit. A later lower or equal vector is then held back until that vector is retired.
- R8: An `eoi` pulse clears the highest set in-service bit only. Lower in-service vectors keep gating new requests.
- R9: Asserting `ack` while `intr_pending` is 0 has no effect: `ack_valid` stays 0 and no state changes.
- R10: Requests with the reserved mode codes 3 and 6 are ignored entirely.
- R11: The trigger-mode bit is written only when a request sets a request bit that was clear: 1 for level, 0 for edge. A repeat request for a vector already requested leaves it alone. `ack_level` reports this bit on a fixed delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming interrupt message strobe |
| req_vector | input | VEC_W | Vector of the message |
| req_mode | input | 3 | Delivery mode code |
| req_level | input | 1 | 1 level-triggered, 0 edge-triggered |
| int_enable | input | 1 | Core's maskable-interrupt enable |
| task_prio | input | VEC_W | Task priority; upper PRIO_W bits are compared |
| eoi | input | 1 | End-of-interrupt pulse |
| ack | input | 1 | Core acknowledge |
| intr_pending | output | 1 | An interrupt is presented to the core |
| ack_valid | output | 1 | Acknowledge honoured this cycle |
| ack_vector | output | VEC_W | Delivered vector |
| ack_class | output | 3 | Delivered class code |
| ack_level | output | 1 | Trigger mode of a delivered fixed vector |

## Verification
The bench builds the block with VEC_W=6 and PRIO_W=4, which gives 64 vectors and 16 priority classes. At that size, every vector can be swept against every task-priority class. Every pair of an in-service vector and a newly requested vector can also be swept, with the expected presentation computed by arithmetic comparison. Directed sequences then cover the ordering among the special classes, dropping of duplicates, gating by the enable input, reserved mode codes, nested retirement and trigger capture.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSV3   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_RSV6   = 3'd6,
        DM_EXTINT = 3'd7
    } dmode_e;

    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_SMI   = 3'd1,
        CLS_NMI   = 3'd2,
        CLS_INIT  = 3'd3,
        CLS_EXT   = 3'd4,
        CLS_FIXED = 3'd5
    } dclass_e;

    localparam int N_SPECIAL = 4;
    localparam int SP_SMI    = 0;
    localparam int SP_NMI    = 1;
    localparam int SP_INIT   = 2;
    localparam int SP_EXT    = 3;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int WIDTH = 256,
    parameter int IDX_W = 8
) (
    input  logic [WIDTH-1:0] vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Highest set bit wins; an empty input reports index 0.
    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = 0; i < WIDTH; i++) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_special_latch.sv
module irq_special_latch #(
    parameter int VEC_W = 8,
    parameter int N     = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              set,
    input  logic [N-1:0]              clr,
    input  logic [VEC_W-1:0]          vec_in,
    output logic [N-1:0]              pend,
    output logic [N-1:0][VEC_W-1:0]   vec_out
);
    typedef struct packed {
        logic [N-1:0]            pend;
        logic [N-1:0][VEC_W-1:0] vec;
    } lat_st_t;

    lat_st_t st_d, st_q;

    // A set only lands on an idle latch; a busy latch drops the new request.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (clr[i]) st_d.pend[i] = 1'b0;
            if (set[i] && !st_q.pend[i]) begin
                st_d.pend[i] = 1'b1;
                st_d.vec[i]  = vec_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend    = st_q.pend;
    assign vec_out = st_q.vec;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R3
        held_vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.pend[g] && !clr[g]) |=> $stable(st_q.vec[g]));
    end
endmodule

// File: rtl/irq_accept_arb.sv
module irq_accept_arb
    import irq_arb_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int PRIO_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vector,
    input  logic [2:0]       req_mode,
    input  logic             req_level,
    input  logic             int_enable,
    input  logic [VEC_W-1:0] task_prio,
    input  logic             eoi,
    input  logic             ack,
    output logic             intr_pending,
    output logic             ack_valid,
    output logic [VEC_W-1:0] ack_vector,
    output logic [2:0]       ack_class,
    output logic             ack_level
);
    localparam int NV = 1 << VEC_W;

    typedef struct packed {
        logic [NV-1:0] irr;
        logic [NV-1:0] isr;
        logic [NV-1:0] tmr;
    } arr_st_t;

    arr_st_t st_d, st_q;

    logic                              irr_any, isr_any;
    logic [VEC_W-1:0]                  irrv, isrv;
    logic [N_SPECIAL-1:0]              sp_pend, sp_set, sp_clr;
    logic [N_SPECIAL-1:0][VEC_W-1:0]   sp_vec;
    logic                              fixed_ok, unmask_pend, ack_fire;
    logic [2:0]                        sel_cls;
    logic [VEC_W-1:0]                  sel_vec;
    logic                              sel_lvl;
    logic [N_SPECIAL-1:0]              sel_onehot;

    irq_prio_enc #(.WIDTH(NV), .IDX_W(VEC_W)) i_irr_enc (
        .vec(st_q.irr), .any(irr_any), .idx(irrv));

    irq_prio_enc #(.WIDTH(NV), .IDX_W(VEC_W)) i_isr_enc (
        .vec(st_q.isr), .any(isr_any), .idx(isrv));

    irq_special_latch #(.VEC_W(VEC_W), .N(N_SPECIAL)) i_latch (
        .clk(clk), .rst_n(rst_n), .set(sp_set), .clr(sp_clr),
        .vec_in(req_vector), .pend(sp_pend), .vec_out(sp_vec));

    // Presentation and selection
    always_comb begin
        fixed_ok    = irr_any && (irrv > isrv) &&
                      (irrv[VEC_W-1 -: PRIO_W] > task_prio[VEC_W-1 -: PRIO_W]);
        unmask_pend = sp_pend[SP_SMI] | sp_pend[SP_NMI] | sp_pend[SP_INIT];
        intr_pending = unmask_pend | (int_enable & (sp_pend[SP_EXT] | fixed_ok));

        sel_onehot = '0;
        sel_lvl    = 1'b0;
        if (sp_pend[SP_SMI]) begin
            sel_cls = CLS_SMI;   sel_vec = sp_vec[SP_SMI];  sel_onehot[SP_SMI] = 1'b1;
        end else if (sp_pend[SP_NMI]) begin
            sel_cls = CLS_NMI;   sel_vec = sp_vec[SP_NMI];  sel_onehot[SP_NMI] = 1'b1;
        end else if (sp_pend[SP_INIT]) begin
            sel_cls = CLS_INIT;  sel_vec = sp_vec[SP_INIT]; sel_onehot[SP_INIT] = 1'b1;
        end else if (sp_pend[SP_EXT]) begin
            sel_cls = CLS_EXT;   sel_vec = sp_vec[SP_EXT];  sel_onehot[SP_EXT] = 1'b1;
        end else begin
            sel_cls = CLS_FIXED; sel_vec = irrv;            sel_lvl = st_q.tmr[irrv];
        end

        ack_fire   = ack & intr_pending;
        ack_valid  = ack_fire;
        ack_class  = ack_fire ? sel_cls : 3'(CLS_NONE);
        ack_vector = ack_fire ? sel_vec : '0;
        ack_level  = ack_fire & sel_lvl;
        sp_clr     = ack_fire ? sel_onehot : '0;

        sp_set[SP_SMI]  = req_valid && (req_mode == DM_SMI);
        sp_set[SP_NMI]  = req_valid && (req_mode == DM_NMI);
        sp_set[SP_INIT] = req_valid && (req_mode == DM_INIT);
        sp_set[SP_EXT]  = req_valid && (req_mode == DM_EXTINT);
    end

    // Array next state
    always_comb begin
        st_d = st_q;
        if (ack_fire && sel_cls == CLS_FIXED) begin
            st_d.irr[irrv] = 1'b0;
            st_d.isr[irrv] = 1'b1;
        end
        if (eoi && isr_any) st_d.isr[isrv] = 1'b0;
        if (req_valid && (req_mode == DM_FIXED || req_mode == DM_LOWEST) &&
            !st_q.irr[req_vector]) begin
            st_d.irr[req_vector] = 1'b1;
            st_d.tmr[req_vector] = req_level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    fixed_to_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_class == CLS_FIXED) |=>
            (st_q.isr[$past(ack_vector)] && !st_q.irr[$past(ack_vector)]));

    // R8
    eoi_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && isr_any) |=> !st_q.isr[$past(isrv)]);

    // R9
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !intr_pending && !eoi) |=> $stable(st_q.isr));

    // R6
    smi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && sp_pend[SP_SMI]) |-> (ack_class == CLS_SMI));

    // R5
    fixed_tpr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_class == CLS_FIXED) |->
            (ack_vector[VEC_W-1 -: PRIO_W] > task_prio[VEC_W-1 -: PRIO_W]));

    // R4
    unmask_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_pend[SP_NMI] && !int_enable) |-> intr_pending);
endmodule

// File: tb/test_irq_accept_arb.sv
module test_irq_accept_arb;
    localparam int VW = 6;
    localparam int NV = 1 << VW;

    logic clk = 1'b0;
    logic rst_n, req_valid, req_level, int_enable, eoi, ack;
    logic [VW-1:0] req_vector, task_prio;
    logic [2:0] req_mode;
    logic intr_pending, ack_valid, ack_level;
    logic [VW-1:0] ack_vector;
    logic [2:0] ack_class;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    irq_accept_arb #(.VEC_W(VW), .PRIO_W(4)) i_irq_accept_arb (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_mode(req_mode), .req_level(req_level), .int_enable(int_enable),
        .task_prio(task_prio), .eoi(eoi), .ack(ack), .intr_pending(intr_pending),
        .ack_valid(ack_valid), .ack_vector(ack_vector), .ack_class(ack_class),
        .ack_level(ack_level));

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; req_valid = 0; req_vector = '0; req_mode = '0; req_level = 0;
        eoi = 0; ack = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic send(int v, int m, bit l);
        req_valid = 1; req_vector = VW'(v); req_mode = 3'(m); req_level = l;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic pulse_eoi();
        eoi = 1;
        @(negedge clk);
        eoi = 0;
    endtask

    task automatic take(output int v, output int c, output int l, output int ok);
        ack = 1;
        #1;
        v = int'(ack_vector); c = int'(ack_class); l = int'(ack_level); ok = int'(ack_valid);
        @(negedge clk);
        ack = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int v, c, l, ok;
        int_enable = 1; task_prio = '0;
        do_reset();

        // R1 reset state
        chk("R1 pending after reset", int'(intr_pending), 0);
        take(v, c, l, ok);
        chk("R1 ack after reset", ok, 0);

        // R5 / R2 sweep: vector against task priority class
        for (int a = 0; a < NV; a++) begin
            for (int t = 0; t < 16; t++) begin
                do_reset();
                task_prio = VW'(t << 2);
                send(a, a & 1, 0);
                chk("R5 tpr gate", int'(intr_pending), ((a > 0) && ((a >> 2) > t)) ? 1 : 0);
                if ((a > 0) && ((a >> 2) > t)) begin
                    take(v, c, l, ok);
                    chk("R2 fixed vector", v, a);
                    chk("R2 fixed class", c, 5);
                end
            end
        end
        task_prio = '0;

        // R7 / R8 sweep: in-service vector against new request
        for (int a = 4; a < NV; a++) begin
            for (int b = 0; b < NV; b++) begin
                do_reset();
                send(a, 0, 0);
                take(v, c, l, ok);
                chk("R7 first delivery", v, a);
                send(b, 0, 0);
                chk("R7 isr gate", int'(intr_pending), (b > a) ? 1 : 0);
                if (b > a) begin
                    take(v, c, l, ok);
                    chk("R7 nested vector", v, b);
                    pulse_eoi();
                    chk("R8 after first eoi", int'(intr_pending), 0);
                    pulse_eoi();
                end else begin
                    pulse_eoi();
                    chk("R8 released", int'(intr_pending), (b >= 4) ? 1 : 0);
                end
            end
        end

        // R8 nested retirement keeps the lower in-service vector
        do_reset();
        send(10, 0, 0); take(v, c, l, ok);
        send(40, 0, 0); take(v, c, l, ok);
        pulse_eoi();
        send(9, 0, 0);
        chk("R8 lower still blocked", int'(intr_pending), 0);
        send(20, 0, 0);
        chk("R8 above remaining", int'(intr_pending), 1);
        take(v, c, l, ok);
        chk("R8 vector", v, 20);

        // R6 ordering
        do_reset();
        send(33, 0, 0); send(11, 7, 0); send(12, 5, 0); send(13, 4, 0); send(14, 2, 0);
        take(v, c, l, ok); chk("R6 smi class", c, 1); chk("R6 smi vec", v, 14);
        take(v, c, l, ok); chk("R6 nmi class", c, 2); chk("R6 nmi vec", v, 13);
        take(v, c, l, ok); chk("R6 init class", c, 3); chk("R6 init vec", v, 12);
        take(v, c, l, ok); chk("R6 ext class", c, 4); chk("R6 ext vec", v, 11);
        take(v, c, l, ok); chk("R6 fixed class", c, 5); chk("R6 fixed vec", v, 33);
        chk("R6 drained", int'(intr_pending), 0);

        // R3 duplicate dropped
        do_reset();
        send(7, 4, 0); send(9, 4, 0);
        take(v, c, l, ok); chk("R3 kept vector", v, 7);
        chk("R3 second dropped", int'(intr_pending), 0);
        send(21, 7, 0); send(22, 7, 0);
        take(v, c, l, ok); chk("R3 ext kept", v, 21);
        chk("R3 ext dropped", int'(intr_pending), 0);

        // R4 / R9 enable gating
        do_reset();
        int_enable = 0;
        send(20, 7, 0);
        chk("R4 ext masked", int'(intr_pending), 0);
        take(v, c, l, ok); chk("R9 ack ignored", ok, 0);
        send(50, 0, 0);
        chk("R4 fixed masked", int'(intr_pending), 0);
        send(3, 4, 0);
        chk("R4 nmi unmasked", int'(intr_pending), 1);
        take(v, c, l, ok); chk("R4 nmi class", c, 2); chk("R4 nmi vec", v, 3);
        chk("R4 masked again", int'(intr_pending), 0);
        int_enable = 1; #1;
        chk("R4 enabled", int'(intr_pending), 1);
        take(v, c, l, ok); chk("R9 ext intact", v, 20); chk("R4 ext class", c, 4);
        take(v, c, l, ok); chk("R9 fixed intact", v, 50);

        // R10 reserved modes
        do_reset();
        send(40, 3, 0); send(41, 6, 1);
        chk("R10 reserved ignored", int'(intr_pending), 0);
        take(v, c, l, ok); chk("R10 no delivery", ok, 0);

        // R11 trigger capture
        do_reset();
        send(20, 0, 1); send(20, 0, 0);
        take(v, c, l, ok); chk("R11 level kept", l, 1);
        send(30, 0, 0);
        take(v, c, l, ok); chk("R11 edge", l, 0);
        send(44, 1, 0); send(44, 0, 1);
        take(v, c, l, ok); chk("R11 edge kept", l, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule